// File: doc/BRIEF.md
# Latch-Based Multiport Register File

A small storage array in which every word is a level-sensitive latch rather than a flip-flop. Each write port registers its enable, address and data on the rising clock edge. A two-level predecoder then selects one word, and that word's latch opens during the following low clock phase. The latch closes again at the next rising edge, so a write presented before rising edge k can be read once rising edge k+1 has passed.

Each read port has its own address comparator and a purely combinational word multiplexer. A generate option can place a hold latch after each read port; that latch is transparent while the clock is high. When more than one write port selects the same word in one cycle, the lowest-numbered port supplies the data. A collision flag is raised for that cycle.

Top module: `latch_regfile`

## Requirements
- R1: A write with its enable high, to an address below DEPTH, stores its data. A read of that address returns the data after the rising edge that follows the capturing edge.
- R2: Every read port selects a word on its own address. Two ports reading different words in the same cycle each return their own word.
- R3: A write port whose enable is low changes no word, whatever address and data it presents.
- R4: When two or more enabled write ports present the same address, the word takes the data of the lowest-numbered of those ports.
- R5: Enabled write ports that present different addresses all store their data in the same cycle.
- R6: wr_collide is 1 during the clock cycle that starts at the rising edge which captures two enabled write ports with equal addresses. In every other cycle it is 0, including when one of the two ports is disabled.
- R7: A read address at or above DEPTH returns all zeros. A write to an address at or above DEPTH changes no stored word.
- R8: During the high phase right after a write is captured, a read of the target word still returns the old contents. The new contents appear after the next rising edge.
- R9: While rst_n is low, wr_collide is 0 and no word is written. After release, wr_collide stays 0 until a collision is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; word latches are open only while it is low |
| rst_n | input | 1 | Active-low reset of the write staging registers and the collision flag |
| wr_en | input | NW | Per-port write enable |
| wr_addr | input | NW*AW | Write addresses, port p in bits [p*AW +: AW] |
| wr_data | input | NW*DW | Write data, port p in bits [p*DW +: DW] |
| rd_addr | input | NR*AW | Read addresses, port r in bits [r*AW +: AW] |
| rd_data | output | NR*DW | Read data, port r in bits [r*DW +: DW] |
| wr_collide | output | 1 | Same-word collision among enabled write ports in the current write cycle |

## Verification
The assertions assume that every input changes only while the clock is low. Under that assumption the registered write controls are stable for the whole latch-open phase, and the array changes only between the falling and the rising edge. They also assume the stored words carry no unknown values at the point where the port-0 landing check indexes them. The stimulus drives every input at falling edges only and fills all words before it checks any read. It compares results just after rising edges, when every word latch is closed.

// File: rtl/lrf_pkg.sv
package lrf_pkg;
   // address width rounded up to whole 2-bit predecode groups
   function automatic int unsigned pad_even(input int unsigned w);
      return ((w + 1) / 2) * 2;
   endfunction

   function automatic int unsigned group_digit(input int unsigned word, input int unsigned grp);
      return (word >> (2 * grp)) % 4;
   endfunction
endpackage

// File: rtl/lrf_wr_decode.sv
module lrf_wr_decode #(
   parameter int DEPTH = 12,
   parameter int AW    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [AW-1:0]    addr,
   output logic [DEPTH-1:0] sel
);
   import lrf_pkg::*;
   localparam int AWP = pad_even(AW);
   localparam int NG  = AWP / 2;

   logic [AWP-1:0] addr_p;
   logic [3:0]     pre [NG];

   assign addr_p = AWP'(addr);

   // first level: each bit pair becomes a 1-of-4 line set
   for (genvar g = 0; g < NG; g++) begin : g_pre
      assign pre[g] = 4'b0001 << addr_p[2*g +: 2];
   end

   // second level: AND one line from every group, gated by the enable
   for (genvar w = 0; w < DEPTH; w++) begin : g_word
      logic [NG-1:0] hit;
      for (genvar g = 0; g < NG; g++) begin : g_grp
         localparam int DIG = group_digit(w, g);
         assign hit[g] = pre[g][DIG];
      end
      assign sel[w] = en & (&hit);
   end

   a_r5_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel));
endmodule

// File: rtl/lrf_read_port.sv
module lrf_read_port #(
   parameter int DEPTH     = 12,
   parameter int AW        = 4,
   parameter int DW        = 8,
   parameter bit OUT_LATCH = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [AW-1:0]      addr,
   input  logic [DEPTH*DW-1:0] words,
   output logic [DW-1:0]      dout
);
   logic [DW-1:0] mux;

   always_comb begin
      mux = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (addr == AW'(i)) mux = words[i*DW +: DW];
      end
   end

   if (OUT_LATCH) begin : g_hold
      logic [DW-1:0] held;
      always_latch begin
         if (clk) held = mux;
      end
      assign dout = held;
      logic unused_rst;
      assign unused_rst = rst_n;
   end else begin : g_pass
      assign dout = mux;
      a_r7_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (32'(addr) >= DEPTH) |-> (dout == '0));
   end
endmodule

// File: rtl/latch_regfile.sv
module latch_regfile #(
   parameter int DEPTH     = 12,
   parameter int DW        = 8,
   parameter int NW        = 2,
   parameter int NR        = 2,
   parameter bit OUT_LATCH = 1'b0,
   parameter int AW        = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NW-1:0]    wr_en,
   input  logic [NW*AW-1:0] wr_addr,
   input  logic [NW*DW-1:0] wr_data,
   input  logic [NR*AW-1:0] rd_addr,
   output logic [NR*DW-1:0] rd_data,
   output logic             wr_collide
);
   if (DEPTH < 2 || DEPTH > (1 << AW)) begin : g_bad_depth
      $error("latch_regfile: DEPTH must lie in 2..2**AW");
   end
   if (NW < 1 || NR < 1 || DW < 1) begin : g_bad_ports
      $error("latch_regfile: port counts and width must be positive");
   end

   // write staging, captured at the rising edge
   logic [NW-1:0]    en_q;
   logic [AW-1:0]    addr_q [NW];
   logic [DW-1:0]    data_q [NW];
   logic             col_d;

   always_comb begin
      col_d = 1'b0;
      for (int i = 0; i < NW; i++) begin
         for (int j = i + 1; j < NW; j++) begin
            if (wr_en[i] && wr_en[j] && (wr_addr[i*AW +: AW] == wr_addr[j*AW +: AW]))
               col_d = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q       <= '0;
         wr_collide <= 1'b0;
      end else begin
         en_q       <= wr_en;
         wr_collide <= col_d;
      end
   end

   for (genvar p = 0; p < NW; p++) begin : g_stage
      always_ff @(posedge clk) begin
         addr_q[p] <= wr_addr[p*AW +: AW];
         data_q[p] <= wr_data[p*DW +: DW];
      end
   end

   // per-port decoders
   logic [DEPTH-1:0] sel [NW];
   for (genvar p = 0; p < NW; p++) begin : g_dec
      lrf_wr_decode #(.DEPTH(DEPTH), .AW(AW)) i_dec (
         .clk  (clk),
         .rst_n(rst_n),
         .en   (en_q[p]),
         .addr (addr_q[p]),
         .sel  (sel[p])
      );
   end

   // storage words: priority data mux, latch open on low clock phase
   logic [DEPTH*DW-1:0] words;
   for (genvar w = 0; w < DEPTH; w++) begin : g_word
      logic [DW-1:0] wdat;
      logic          any;
      logic [DW-1:0] q;
      always_comb begin
         wdat = '0;
         any  = 1'b0;
         for (int p = NW - 1; p >= 0; p--) begin
            if (sel[p][w]) begin
               wdat = data_q[p];
               any  = 1'b1;
            end
         end
      end
      always_latch begin
         if (!clk && any) q = wdat;
      end
      assign words[w*DW +: DW] = q;
   end

   // read ports
   for (genvar r = 0; r < NR; r++) begin : g_rd
      lrf_read_port #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .OUT_LATCH(OUT_LATCH)) i_rd (
         .clk  (clk),
         .rst_n(rst_n),
         .addr (rd_addr[r*AW +: AW]),
         .words(words),
         .dout (rd_data[r*DW +: DW])
      );
   end

   a_r4_port0_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[0] && (32'(addr_q[0]) < DEPTH)) |-> (words[32'(addr_q[0])*DW +: DW] == data_q[0]));

   a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == '0) |-> $stable(words));

   a_r6_collide_two_ports: assert property (@(posedge clk) disable iff (!rst_n)
      wr_collide |-> ($countones(en_q) >= 2));
endmodule

// File: tb/test_latch_regfile.sv
`timescale 1ns/1ps
module test_latch_regfile;
   localparam int DEPTH = 12;
   localparam int DW    = 8;
   localparam int NW    = 2;
   localparam int NR    = 2;
   localparam int AW    = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NW-1:0]    wr_en = '0;
   logic [NW*AW-1:0] wr_addr = '0;
   logic [NW*DW-1:0] wr_data = '0;
   logic [NR*AW-1:0] rd_addr = '0;
   logic [NR*DW-1:0] rd_data;
   logic             wr_collide;

   always #2 clk = ~clk;

   latch_regfile #(.DEPTH(DEPTH), .DW(DW), .NW(NW), .NR(NR), .AW(AW)) i_latch_regfile (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .wr_collide(wr_collide)
   );

   typedef struct {
      bit          is_col;
      int          port;
      logic [7:0]  exp;
      string       req;
   } item_t;

   item_t      sbq[$];
   logic [7:0] model [DEPTH];
   int         checks = 0;
   int         failures = 0;
   bit         done = 1'b0;

   // monitor: compares after every rising edge, latches closed
   initial begin
      forever begin
         @(posedge clk);
         #1;
         while (sbq.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it  = sbq.pop_front();
            act = it.is_col ? {7'd0, wr_collide} : rd_data[it.port*DW +: DW];
            checks++;
            if (act !== it.exp) begin
               failures++;
               $display("FAIL %s: port %0d actual=%0h expected=%0h", it.req, it.port, act, it.exp);
            end
         end
      end
   end

   task automatic set_wr(input int p, input bit en, input int a, input int d);
      wr_en[p] = en;
      wr_addr[p*AW +: AW] = AW'(a);
      wr_data[p*DW +: DW] = DW'(d);
   endtask

   // commit the driven write ports into the model, lowest port last so it wins
   task automatic commit();
      for (int p = NW - 1; p >= 0; p--) begin
         int a;
         a = int'(wr_addr[p*AW +: AW]);
         if (wr_en[p] && a < DEPTH) model[a] = wr_data[p*DW +: DW];
      end
   endtask

   task automatic exp_rd(input int p, input int a, input logic [7:0] e, input string req);
      item_t it;
      rd_addr[p*AW +: AW] = AW'(a);
      it.is_col = 1'b0; it.port = p; it.exp = e; it.req = req;
      sbq.push_back(it);
   endtask

   task automatic exp_col(input bit e, input string req);
      item_t it;
      it.is_col = 1'b1; it.port = 0; it.exp = {7'd0, e}; it.req = req;
      sbq.push_back(it);
   endtask

   task automatic idle();
      @(negedge clk);
      wr_en = '0;
   endtask

   task automatic check_all(input string req);
      for (int a = 0; a < DEPTH; a++) begin
         @(negedge clk);
         wr_en = '0;
         exp_rd(a % NR, a, model[a], req);
      end
   endtask

   initial begin
      for (int a = 0; a < DEPTH; a++) model[a] = 'x;
      repeat (3) @(negedge clk);
      exp_col(1'b0, "R9");
      @(negedge clk);
      rst_n = 1'b1;
      exp_col(1'b0, "R9");

      // fill every word, ports alternating (R1)
      for (int a = 0; a < DEPTH; a++) begin
         @(negedge clk);
         wr_en = '0;
         set_wr(a % NW, 1'b1, a, a * 13 + 5);
         commit();
      end
      idle();
      check_all("R1");

      // R2: two read ports on different words in the same cycle
      @(negedge clk);
      exp_rd(0, 3, model[3], "R2");
      exp_rd(1, 8, model[8], "R2");
      @(negedge clk);
      exp_rd(0, 11, model[11], "R2");
      exp_rd(1, 0, model[0], "R2");

      // R3: disabled port presents address and data
      @(negedge clk);
      set_wr(0, 1'b0, 5, 8'hAA);
      set_wr(1, 1'b0, 5, 8'hBB);
      exp_col(1'b0, "R3");
      idle();
      @(negedge clk);
      exp_rd(0, 5, model[5], "R3");

      // R5: two ports, two words, same cycle
      @(negedge clk);
      set_wr(0, 1'b1, 1, 8'h11);
      set_wr(1, 1'b1, 2, 8'h22);
      commit();
      exp_col(1'b0, "R6");
      idle();
      @(negedge clk);
      exp_rd(0, 1, 8'h11, "R5");
      exp_rd(1, 2, 8'h22, "R5");

      // R4 and R6: same word on both ports
      @(negedge clk);
      set_wr(0, 1'b1, 7, 8'h5A);
      set_wr(1, 1'b1, 7, 8'hA5);
      commit();
      exp_col(1'b1, "R6");
      idle();
      exp_col(1'b0, "R6");
      @(negedge clk);
      exp_rd(0, 7, 8'h5A, "R4");
      exp_rd(1, 7, 8'h5A, "R4");

      // R6: same address but port 0 disabled; port 1 writes alone
      @(negedge clk);
      set_wr(0, 1'b0, 9, 8'h99);
      set_wr(1, 1'b1, 9, 8'h66);
      commit();
      exp_col(1'b0, "R6");
      idle();
      @(negedge clk);
      exp_rd(1, 9, 8'h66, "R6");

      // R7: out-of-range read and write
      @(negedge clk);
      exp_rd(0, 13, 8'h00, "R7");
      exp_rd(1, 15, 8'h00, "R7");
      @(negedge clk);
      set_wr(1, 1'b1, 14, 8'hFF);
      set_wr(0, 1'b1, 12, 8'hEE);
      commit();
      idle();
      check_all("R7");

      // R8: old contents in the high phase, new after the next edge
      @(negedge clk);
      set_wr(0, 1'b1, 4, 8'h3C);
      exp_rd(0, 4, model[4], "R8");
      commit();
      @(negedge clk);
      wr_en = '0;
      exp_rd(0, 4, 8'h3C, "R8");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule